// File: doc/BRIEF.md
# Host Bridge Configuration Registers with Interrupt Steering

This block holds the 256-byte configuration space of a host bridge function. A simple byte-wide access port reads and writes it: an 8-bit offset, a write strobe, write data and registered read data. The identification bytes are fixed: the vendor and device codes come from parameters, and the revision, class code and header type are constants. Only the command/status window and the device-specific region above 0x3F accept writes. Everything else reads back its fixed value and ignores writes.

Four steering bytes map the bridge's PCI interrupt lines A through D onto one of sixteen legacy IRQ numbers. The block gives out each line's selected IRQ number and a valid flag. It also merges the incoming interrupt requests into a registered 16-bit IRQ request vector. Two more bytes control the disk-controller channels: one swaps which physical channel takes the primary address set, and the other enables the two channels. The block decodes these into per-channel enables. The two ROM control bytes are passed out raw for other logic.

Top module: `hb_cfg_space`

## Requirements
- R1: After a synchronous reset these bytes read back: 0x04=0x07, 0x05=0x00, 0x06=0x80, 0x07=0x02, 0x08=0x02, 0x09=0x00, 0x0A=0x00, 0x0B=0x06, 0x0E=0x00, 0xD0=0x78, 0xD1=0xFF. All other writable bytes read 0x00, all route valid flags are 0 and irq_req is 0.
- R2: Offsets 0x00/0x01 read VENDOR_ID low/high byte and 0x02/0x03 read DEVICE_ID low/high byte.
- R3: A write to any offset in 0x00–0x03 or 0x08–0x3F is ignored. The byte keeps its fixed value, and offsets in that range with no defined content read 0x00.
- R4: A write to any offset in 0x04–0x07 or 0x40–0xFF is stored and read back unchanged.
- R5: cfg_rdata shows the byte at the offset presented one clock edge earlier. A read and a write to the same offset in the same cycle return the old value.
- R6: Offsets 0xC0, 0xC1, 0xC2, 0xC3 steer lines A, B, C, D. Bit 7 of the byte is the route valid flag and bits 3:0 are the IRQ number. Both appear on route_vld[n] and route_irq[4n+3:4n] right after the write edge. Line A is n=0.
- R7: irq_req[k] is 1 one cycle after int_req[n] is 1 on some line n whose route is valid and whose IRQ number is k. A line whose valid flag is 0 raises nothing, and lines sharing an IRQ number are ORed.
- R8: ide_swap equals bit 1 of offset 0x59.
- R9: With ide_swap=0, bit 7 of offset 0x58 enables the primary channel and bit 6 enables the secondary channel. With ide_swap=1 the two bits trade places.
- R10: rom_ctl equals {byte 0xD1, byte 0xD0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_we | input | 1 | Write strobe |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Registered read data |
| int_req | input | 4 | Interrupt requests, lines A..D in bits 0..3 |
| route_irq | output | 16 | IRQ number per line, 4 bits each |
| route_vld | output | 4 | Route valid flag per line |
| irq_req | output | 16 | Registered merged IRQ request vector |
| ide_swap | output | 1 | Channel address swap |
| ide_pri_en | output | 1 | Primary channel enable |
| ide_sec_en | output | 1 | Secondary channel enable |
| rom_ctl | output | 16 | Raw ROM control bytes |

## Verification
A read and a write can hit the same offset in one cycle. The bench provokes this by holding the strobe and the offset of a known byte together for one edge. It expects the old byte on cfg_rdata and then reads the new byte. A steering rewrite can also land while requests are being merged, and two valid lines can name the same IRQ. The bench programs lines A and B onto one IRQ and leaves a disabled line on another. It then checks that the request vector shows the single ORed bit and nothing from the disabled line.

// File: rtl/hbc_pkg.sv
package hbc_pkg;
  localparam int unsigned CFG_BYTES  = 256;
  localparam int unsigned ADDR_W     = 8;
  localparam logic [7:0]  STEER_BASE = 8'hC0;
  localparam logic [7:0]  IDE_EN_OFF = 8'h58;
  localparam logic [7:0]  IDE_CF_OFF = 8'h59;
  localparam logic [7:0]  ROM_LO_OFF = 8'hD0;
  localparam logic [7:0]  ROM_HI_OFF = 8'hD1;
  localparam logic [7:0]  REVISION   = 8'h02;
  localparam logic [7:0]  CLASS_BASE = 8'h06;

  function automatic logic cfg_writable(input int unsigned off);
    return (off >= 4 && off < 8) || (off >= 64);
  endfunction

  function automatic logic [7:0] cfg_reset_val(input int unsigned off);
    case (off)
      4:       return 8'h07;
      6:       return 8'h80;
      7:       return 8'h02;
      8'hD0:   return 8'h78;
      8'hD1:   return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/hbc_regfile.sv
module hbc_regfile
  import hbc_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h1D5E,
  parameter logic [15:0] DEVICE_ID = 16'h0A31,
  parameter int unsigned NLINES    = 4,
  parameter int unsigned SEL_W     = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      we,
  input  logic [7:0]                wdata,
  output logic [7:0]                rdata,
  output logic [NLINES-1:0]         steer_vld,
  output logic [NLINES*SEL_W-1:0]   steer_sel,
  output logic [1:0]                ide_en_bits,
  output logic                      ide_swap_bit,
  output logic [15:0]               rom_bytes
);
  function automatic logic [7:0] fixed_byte(input int unsigned off);
    case (off)
      0:       return VENDOR_ID[7:0];
      1:       return VENDOR_ID[15:8];
      2:       return DEVICE_ID[7:0];
      3:       return DEVICE_ID[15:8];
      8:       return REVISION;
      11:      return CLASS_BASE;
      default: return 8'h00;
    endcase
  endfunction

  logic [7:0] byte_q [CFG_BYTES];

  for (genvar i = 0; i < CFG_BYTES; i++) begin : g_byte
    logic [7:0] q;
    if (cfg_writable(i)) begin : g_rw
      always_ff @(posedge clk) begin
        if (rst)
          q <= cfg_reset_val(i);
        else if (we && addr == ADDR_W'(i))
          q <= wdata;
      end
    end else begin : g_ro
      assign q = fixed_byte(i);
    end
    assign byte_q[i] = q;
  end

  // Read-first: a same-cycle write lands after the old byte is captured.
  always_ff @(posedge clk) begin
    if (rst) rdata <= 8'h00;
    else     rdata <= byte_q[addr];
  end

  for (genvar l = 0; l < NLINES; l++) begin : g_steer
    assign steer_vld[l]                 = byte_q[STEER_BASE + l][7];
    assign steer_sel[l*SEL_W +: SEL_W]  = byte_q[STEER_BASE + l][SEL_W-1:0];
  end

  assign ide_en_bits  = byte_q[IDE_EN_OFF][7:6];
  assign ide_swap_bit = byte_q[IDE_CF_OFF][1];
  assign rom_bytes    = {byte_q[ROM_HI_OFF], byte_q[ROM_LO_OFF]};
endmodule

// File: rtl/hbc_irq_router.sv
module hbc_irq_router #(
  parameter int unsigned NLINES = 4,
  parameter int unsigned SEL_W  = 4,
  localparam int unsigned NIRQ  = 1 << SEL_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NLINES-1:0]       int_req,
  input  logic [NLINES-1:0]       vld,
  input  logic [NLINES*SEL_W-1:0] sel,
  output logic [NIRQ-1:0]         irq_req
);
  logic [NIRQ-1:0] irq_nxt;

  always_comb begin
    irq_nxt = '0;
    for (int l = 0; l < NLINES; l++) begin
      if (vld[l] && int_req[l])
        irq_nxt[sel[l*SEL_W +: SEL_W]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_req <= '0;
    else     irq_req <= irq_nxt;
  end
endmodule

// File: rtl/hbc_ide_map.sv
module hbc_ide_map (
  input  logic [1:0] en_bits,   // [1] = byte bit 7, [0] = byte bit 6
  input  logic       swap,
  output logic       pri_en,
  output logic       sec_en
);
  always_comb begin
    if (swap) begin
      pri_en = en_bits[0];
      sec_en = en_bits[1];
    end else begin
      pri_en = en_bits[1];
      sec_en = en_bits[0];
    end
  end
endmodule

// File: rtl/hb_cfg_space.sv
module hb_cfg_space #(
  parameter logic [15:0] VENDOR_ID = 16'h1D5E,
  parameter logic [15:0] DEVICE_ID = 16'h0A31,
  parameter int unsigned NLINES    = 4,
  parameter int unsigned SEL_W     = 4,
  localparam int unsigned NIRQ     = 1 << SEL_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [7:0]              cfg_addr,
  input  logic                    cfg_we,
  input  logic [7:0]              cfg_wdata,
  output logic [7:0]              cfg_rdata,
  input  logic [NLINES-1:0]       int_req,
  output logic [NLINES*SEL_W-1:0] route_irq,
  output logic [NLINES-1:0]       route_vld,
  output logic [NIRQ-1:0]         irq_req,
  output logic                    ide_swap,
  output logic                    ide_pri_en,
  output logic                    ide_sec_en,
  output logic [15:0]             rom_ctl
);
  logic [1:0] ide_en_bits;

  hbc_regfile #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID),
    .NLINES(NLINES), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(cfg_addr), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .steer_vld(route_vld), .steer_sel(route_irq),
    .ide_en_bits(ide_en_bits), .ide_swap_bit(ide_swap), .rom_bytes(rom_ctl)
  );

  hbc_irq_router #(.NLINES(NLINES), .SEL_W(SEL_W)) u_route (
    .clk(clk), .rst(rst), .int_req(int_req), .vld(route_vld),
    .sel(route_irq), .irq_req(irq_req)
  );

  hbc_ide_map u_ide (
    .en_bits(ide_en_bits), .swap(ide_swap),
    .pri_en(ide_pri_en), .sec_en(ide_sec_en)
  );
endmodule

// File: rtl/hb_cfg_space_chk.sv
module hb_cfg_space_chk #(
  parameter int unsigned NLINES = 4,
  parameter int unsigned SEL_W  = 4,
  localparam int unsigned NIRQ  = 1 << SEL_W
) (
  input logic                    clk,
  input logic                    rst,
  input logic [7:0]              cfg_addr,
  input logic                    cfg_we,
  input logic [7:0]              cfg_wdata,
  input logic [NLINES-1:0]       int_req,
  input logic [NLINES*SEL_W-1:0] route_irq,
  input logic [NLINES-1:0]       route_vld,
  input logic [NIRQ-1:0]         irq_req,
  input logic                    ide_swap,
  input logic [15:0]             rom_ctl
);
  logic steer_hit;
  assign steer_hit = cfg_we && (cfg_addr >= 8'hC0) && (cfg_addr < 8'hC0 + 8'(NLINES));

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (route_vld == '0 && irq_req == '0 && rom_ctl == 16'hFF78));

  for (genvar l = 0; l < NLINES; l++) begin : g_line
    assert_steer_load_R6: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && cfg_addr == 8'hC0 + 8'(l)) |=>
        (route_vld[l] == $past(cfg_wdata[7]) &&
         route_irq[l*SEL_W +: SEL_W] == $past(cfg_wdata[SEL_W-1:0])));
  end

  assert_steer_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !steer_hit |=> ($stable(route_vld) && $stable(route_irq)));

  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (int_req == '0) |=> (irq_req == '0));

  assert_irq_count_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(irq_req) <= $past($countones(int_req))));

  assert_swap_load_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == 8'h59) |=> (ide_swap == $past(cfg_wdata[1])));

  assert_rom_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(cfg_we && (cfg_addr == 8'hD0 || cfg_addr == 8'hD1)) |=> $stable(rom_ctl));
endmodule

bind hb_cfg_space hb_cfg_space_chk #(.NLINES(NLINES), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
  .cfg_wdata(cfg_wdata), .int_req(int_req), .route_irq(route_irq),
  .route_vld(route_vld), .irq_req(irq_req), .ide_swap(ide_swap),
  .rom_ctl(rom_ctl)
);

// File: tb/tb_hb_cfg_space.sv
module tb_hb_cfg_space;
  localparam logic [15:0] VID = 16'h1D5E;
  localparam logic [15:0] DID = 16'h0A31;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cfg_addr = 8'h00;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic [3:0]  int_req = 4'h0;
  logic [15:0] route_irq;
  logic [3:0]  route_vld;
  logic [15:0] irq_req;
  logic        ide_swap, ide_pri_en, ide_sec_en;
  logic [15:0] rom_ctl;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  hb_cfg_space #(.VENDOR_ID(VID), .DEVICE_ID(DID)) dut (
    .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .int_req(int_req),
    .route_irq(route_irq), .route_vld(route_vld), .irq_req(irq_req),
    .ide_swap(ide_swap), .ide_pri_en(ide_pri_en), .ide_sec_en(ide_sec_en),
    .rom_ctl(rom_ctl)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 route_vld", 32'(route_vld), 32'h0);
    chk("R1 irq_req", 32'(irq_req), 32'h0);
    chk("R10 rom_ctl reset", 32'(rom_ctl), 32'hFF78);
    rd(8'h04, d); chk("R1 cmd lo", 32'(d), 32'h07);
    rd(8'h05, d); chk("R1 cmd hi", 32'(d), 32'h00);
    rd(8'h06, d); chk("R1 status lo", 32'(d), 32'h80);
    rd(8'h07, d); chk("R1 status hi", 32'(d), 32'h02);
    rd(8'h08, d); chk("R1 revision", 32'(d), 32'h02);
    rd(8'h09, d); chk("R1 class 0", 32'(d), 32'h00);
    rd(8'h0A, d); chk("R1 class 1", 32'(d), 32'h00);
    rd(8'h0B, d); chk("R1 class 2", 32'(d), 32'h06);
    rd(8'h0E, d); chk("R1 header", 32'(d), 32'h00);
    rd(8'hD0, d); chk("R1 D0", 32'(d), 32'h78);
    rd(8'hD1, d); chk("R1 D1", 32'(d), 32'hFF);
    rd(8'h40, d); chk("R1 0x40", 32'(d), 32'h00);
    rd(8'hC2, d); chk("R1 0xC2", 32'(d), 32'h00);
  endtask

  task automatic t_ident;
    logic [7:0] d;
    rd(8'h00, d); chk("R2 vendor lo", 32'(d), 32'(VID[7:0]));
    rd(8'h01, d); chk("R2 vendor hi", 32'(d), 32'(VID[15:8]));
    rd(8'h02, d); chk("R2 device lo", 32'(d), 32'(DID[7:0]));
    rd(8'h03, d); chk("R2 device hi", 32'(d), 32'(DID[15:8]));
  endtask

  task automatic t_readonly;
    logic [7:0] d;
    wr(8'h00, 8'hFF); rd(8'h00, d); chk("R3 0x00", 32'(d), 32'(VID[7:0]));
    wr(8'h03, 8'hFF); rd(8'h03, d); chk("R3 0x03", 32'(d), 32'(DID[15:8]));
    wr(8'h08, 8'hFF); rd(8'h08, d); chk("R3 0x08", 32'(d), 32'h02);
    wr(8'h0B, 8'h00); rd(8'h0B, d); chk("R3 0x0B", 32'(d), 32'h06);
    wr(8'h20, 8'h55); rd(8'h20, d); chk("R3 0x20", 32'(d), 32'h00);
    wr(8'h3F, 8'hA5); rd(8'h3F, d); chk("R3 0x3F", 32'(d), 32'h00);
  endtask

  task automatic t_writable;
    logic [7:0] d;
    wr(8'h04, 8'h5A); rd(8'h04, d); chk("R4 0x04", 32'(d), 32'h5A);
    wr(8'h07, 8'hC3); rd(8'h07, d); chk("R4 0x07", 32'(d), 32'hC3);
    wr(8'h40, 8'h11); rd(8'h40, d); chk("R4 0x40", 32'(d), 32'h11);
    wr(8'h9E, 8'h3C); rd(8'h9E, d); chk("R4 0x9E", 32'(d), 32'h3C);
    wr(8'hFF, 8'hE7); rd(8'hFF, d); chk("R4 0xFF", 32'(d), 32'hE7);
  endtask

  task automatic t_collision;
    logic [7:0] d;
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'h40; cfg_wdata = 8'h22;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R5 same-cycle old value", 32'(cfg_rdata), 32'h11);
    rd(8'h40, d); chk("R5 new value after", 32'(d), 32'h22);
  endtask

  task automatic t_steer;
    wr(8'hC0, 8'h85);
    chk("R6 A vld", 32'(route_vld[0]), 32'h1);
    chk("R6 A irq", 32'(route_irq[3:0]), 32'h5);
    wr(8'hC1, 8'hF5);
    wr(8'hC2, 8'h0A);
    wr(8'hC3, 8'h8F);
    chk("R6 all vld", 32'(route_vld), 32'b1011);
    chk("R6 all irq", 32'(route_irq), 32'hFA55);
  endtask

  task automatic t_irq;
    @(negedge clk); int_req = 4'b0100;
    @(negedge clk); chk("R7 disabled line", 32'(irq_req), 32'h0);
    int_req = 4'b0001;
    @(negedge clk); chk("R7 line A", 32'(irq_req), 32'h0020);
    int_req = 4'b0011;
    @(negedge clk); chk("R7 shared OR", 32'(irq_req), 32'h0020);
    int_req = 4'b1000;
    @(negedge clk); chk("R7 line D", 32'(irq_req), 32'h8000);
    int_req = 4'b1111;
    @(negedge clk); chk("R7 all lines", 32'(irq_req), 32'h8020);
    int_req = 4'b0000;
    @(negedge clk); chk("R7 idle", 32'(irq_req), 32'h0);
  endtask

  task automatic t_ide;
    wr(8'h58, 8'h80); wr(8'h59, 8'h00);
    chk("R8 swap off", 32'(ide_swap), 32'h0);
    chk("R9 pri from bit7", 32'({ide_pri_en, ide_sec_en}), 32'b10);
    wr(8'h59, 8'h02);
    chk("R8 swap on", 32'(ide_swap), 32'h1);
    chk("R9 swapped bit7", 32'({ide_pri_en, ide_sec_en}), 32'b01);
    wr(8'h58, 8'h40);
    chk("R9 swapped bit6", 32'({ide_pri_en, ide_sec_en}), 32'b10);
    wr(8'h58, 8'hC0);
    chk("R9 both", 32'({ide_pri_en, ide_sec_en}), 32'b11);
  endtask

  task automatic t_rom;
    wr(8'hD0, 8'h12);
    chk("R10 low byte", 32'(rom_ctl), 32'hFF12);
    wr(8'hD1, 8'h34);
    chk("R10 high byte", 32'(rom_ctl), 32'h3412);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ident();
    t_readonly();
    t_writable();
    t_collision();
    t_steer();
    t_irq();
    t_ide();
    t_rom();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule